// File: doc/BRIEF.md
# Endurance Cycling Engine

This block wears out one word of a memory, or a few neighbouring words, by writing and reading it again and again. Each iteration at an address writes an alternating bit pattern, reads it back and checks it, writes the complementary pattern, and reads and checks that too. The engine then moves to the next address of the configured window, returns to the first address after the last one, and repeats for as long as its run input stays high.

Two wide counters record how many write requests and how many read requests have gone out. They are wide enough for the very long campaigns that endurance testing needs, beyond 10^15 accesses. When a read returns data that differs from the pattern written just before, the engine pulses an error strobe for one cycle. With the strobe it gives a record: the running error total, both access counts at that read, the address, and the data actually returned. The memory side is a plain request port with a read-data valid strobe, so any device-specific bus timing sits in an adapter outside this block.

Top module: `endur_engine`

## Requirements
- R1: After reset, mem_req, busy and err_valid are 0, and wr_count, rd_count and err_total are all 0.
- R2: At each address the engine issues, in order: a write of the pattern P (bit i is 1 for even i, so 0x55 for 8 bits), a read, a write of ~P, and a read. After a read request it issues no request until mem_rvalid has been seen, and the request that follows comes in the cycle after that.
- R3: wr_count rises by exactly 1 for each write request and rd_count by exactly 1 for each read request. Both are CNT_W bits wide (52 by default) and change at no other time.
- R4: When the data returned with mem_rvalid differs from the pattern of the preceding write, err_valid is high for exactly one cycle, the cycle after mem_rvalid, and err_total goes up by 1 in that cycle. Matching data raises no pulse.
- R5: While err_valid is high, err_rd_count and err_wr_count hold the access counts including the failing read, err_addr holds its address, and err_data holds the wrong data returned.
- R6: After the fourth access at an address, the next iteration uses the address plus one. After the window's upper bound it wraps back to cfg_start.
- R7: If cfg_start is greater than cfg_end, only cfg_start is exercised.
- R8: When run is low, the engine finishes the iteration in progress and then goes idle: busy falls and no request is issued while idle. The counters and err_total keep their values.
- R9: When run rises from idle, the first request is a write of P to cfg_start, and the counters carry on from their held values. cfg_start and cfg_end are sampled only at this point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High to cycle; low stops at the next iteration boundary |
| cfg_start | input | ADDR_W | First address of the window |
| cfg_end | input | ADDR_W | Last address of the window |
| mem_req | output | 1 | Memory access request, one cycle per access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | Engine is cycling |
| wr_count | output | CNT_W | Total write requests |
| rd_count | output | CNT_W | Total read requests |
| err_valid | output | 1 | One-cycle miscompare strobe |
| err_total | output | ERR_W | Miscompares seen so far |
| err_wr_count | output | CNT_W | Write count at the failing read |
| err_rd_count | output | CNT_W | Read count at the failing read |
| err_addr | output | ADDR_W | Failing address |
| err_data | output | DATA_W | Wrong data returned |

## Verification
The bench builds the engine with ADDR_W=6, DATA_W=8, CNT_W=52 and ERR_W=16. The 64-word space lets a bench memory model hold every word, including a window at the very top of the address space, where the wrap has no room to overflow. The 8-bit data makes every corrupted read differ from the expected pattern in at least one bit. The counters keep their full 52-bit width, so the increment path checked is the one the block is built with, though a campaign long enough to approach its top is out of reach in simulation.

// File: rtl/endur_pkg.sv
// Shared types for the endurance cycling engine.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package endur_pkg;

    // Steps of one four-access iteration; WT_* wait for read data
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WR_A = 3'd1,
        ST_RD_A = 3'd2,
        ST_WT_A = 3'd3,
        ST_WR_B = 3'd4,
        ST_RD_B = 3'd5,
        ST_WT_B = 3'd6
    } step_t;

endpackage

// File: rtl/endur_seq.sv
// Iteration sequencer: walks write-A, read-A, write-B, read-B at one address,
// then steps through the latched window with wrap-around.
// Assumes: one request per cycle is accepted; mem_rvalid arrives at some later cycle.
module endur_seq
    import endur_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_end,
    input  logic              mem_rvalid,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              use_b,
    output logic              wr_evt,
    output logic              rd_evt,
    output logic              chk_evt,
    output logic              busy
);

    step_t             st;
    logic [ADDR_W-1:0] win_lo;
    logic [ADDR_W-1:0] win_hi;
    logic [ADDR_W-1:0] addr_nxt;

    // Next address in the window, wrapping from the upper bound to the lower
    always_comb begin
        if (cur_addr == win_hi) addr_nxt = win_lo;
        else                    addr_nxt = cur_addr + {{(ADDR_W-1){1'b0}}, 1'b1};
    end

    // State, window and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            win_lo   <= '0;
            win_hi   <= '0;
            cur_addr <= '0;
        end else begin
            case (st)
                ST_IDLE: if (run) begin
                    win_lo   <= cfg_start;
                    win_hi   <= (cfg_start > cfg_end) ? cfg_start : cfg_end;
                    cur_addr <= cfg_start;
                    st       <= ST_WR_A;
                end
                ST_WR_A: st <= ST_RD_A;
                ST_RD_A: st <= ST_WT_A;
                ST_WT_A: if (mem_rvalid) st <= ST_WR_B;
                ST_WR_B: st <= ST_RD_B;
                ST_RD_B: st <= ST_WT_B;
                ST_WT_B: if (mem_rvalid) begin
                    cur_addr <= addr_nxt;
                    st       <= run ? ST_WR_A : ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Decode request strobes and pattern select from the current step
    always_comb begin
        wr_evt  = (st == ST_WR_A) || (st == ST_WR_B);
        rd_evt  = (st == ST_RD_A) || (st == ST_RD_B);
        mem_req = wr_evt || rd_evt;
        mem_we  = wr_evt;
        use_b   = (st == ST_WR_B) || (st == ST_RD_B) || (st == ST_WT_B);
        chk_evt = ((st == ST_WT_A) || (st == ST_WT_B)) && mem_rvalid;
        busy    = (st != ST_IDLE);
    end

endmodule

// File: rtl/endur_ctr.sv
// Plain wide event counter; holds its value when inc is low.
// Assumes: the width covers the longest campaign, so no wrap handling.
module endur_ctr #(
    parameter int W = 52
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Count one per asserted inc
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + ONE;
    end

endmodule

// File: rtl/endur_cmp.sv
// Read checker: compares returned data with the expected pattern and
// registers an error record with a one-cycle strobe on a mismatch.
// Assumes: chk_evt is high for exactly one cycle per completed read.
module endur_cmp #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 52,
    parameter int ERR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_evt,
    input  logic [DATA_W-1:0] exp_data,
    input  logic [DATA_W-1:0] got_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic [CNT_W-1:0]  rd_cnt,
    output logic              err_valid,
    output logic [ERR_W-1:0]  err_total,
    output logic [CNT_W-1:0]  err_wr_count,
    output logic [CNT_W-1:0]  err_rd_count,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_data
);

    logic miss;
    assign miss = chk_evt && (got_data != exp_data);

    // Capture the record and bump the total on a miscompare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid    <= 1'b0;
            err_total    <= '0;
            err_wr_count <= '0;
            err_rd_count <= '0;
            err_addr     <= '0;
            err_data     <= '0;
        end else begin
            err_valid <= miss;
            if (miss) begin
                err_total    <= err_total + {{(ERR_W-1){1'b0}}, 1'b1};
                err_wr_count <= wr_cnt;
                err_rd_count <= rd_cnt;
                err_addr     <= addr;
                err_data     <= got_data;
            end
        end
    end

endmodule

// File: rtl/endur_engine.sv
// Endurance cycling engine top: sequencer, two access counters and the
// read checker. Patterns are built per bit: even bits 1, odd bits 0.
// Assumes: memory adapter accepts one request per cycle and returns
// read data later with mem_rvalid.
module endur_engine
    import endur_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 52,
    parameter int ERR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_end,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic [CNT_W-1:0]  wr_count,
    output logic [CNT_W-1:0]  rd_count,
    output logic              err_valid,
    output logic [ERR_W-1:0]  err_total,
    output logic [CNT_W-1:0]  err_wr_count,
    output logic [CNT_W-1:0]  err_rd_count,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_data
);

    logic [DATA_W-1:0] pat_a;
    logic [DATA_W-1:0] pat_b;
    logic [DATA_W-1:0] pat_cur;
    logic              use_b;
    logic              wr_evt;
    logic              rd_evt;
    logic              chk_evt;

    // Alternating pattern, one bit per generate step
    for (genvar g = 0; g < DATA_W; g++) begin : g_pat
        assign pat_a[g] = ((g % 2) == 0) ? 1'b1 : 1'b0;
    end
    assign pat_b     = ~pat_a;
    assign pat_cur   = use_b ? pat_b : pat_a;
    assign mem_wdata = pat_cur;

    endur_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cfg_start  (cfg_start),
        .cfg_end    (cfg_end),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .cur_addr   (mem_addr),
        .use_b      (use_b),
        .wr_evt     (wr_evt),
        .rd_evt     (rd_evt),
        .chk_evt    (chk_evt),
        .busy       (busy)
    );

    endur_ctr #(.W(CNT_W)) wr_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wr_evt),
        .count (wr_count)
    );

    endur_ctr #(.W(CNT_W)) rd_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rd_evt),
        .count (rd_count)
    );

    endur_cmp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .ERR_W  (ERR_W)
    ) cmp_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .chk_evt      (chk_evt),
        .exp_data     (pat_cur),
        .got_data     (mem_rdata),
        .addr         (mem_addr),
        .wr_cnt       (wr_count),
        .rd_cnt       (rd_count),
        .err_valid    (err_valid),
        .err_total    (err_total),
        .err_wr_count (err_wr_count),
        .err_rd_count (err_rd_count),
        .err_addr     (err_addr),
        .err_data     (err_data)
    );

endmodule

// File: rtl/endur_engine_chk.sv
// Protocol and counter properties for endur_engine, attached by bind.
// Assumes: reset is synchronous and active low.
module endur_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 52,
    parameter int ERR_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic [CNT_W-1:0]  wr_count,
    input logic [CNT_W-1:0]  rd_count,
    input logic              err_valid,
    input logic [ERR_W-1:0]  err_total
);

    // R2
    rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);

    // R2
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (mem_req && !mem_we && $stable(mem_addr)));

    // R3
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (wr_count == $past(wr_count) + CNT_W'(1)));

    // R3
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (rd_count == $past(rd_count) + CNT_W'(1)));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && !mem_we) |=> $stable(rd_count));

    // R4
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);

    // R4
    err_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(err_total) |-> err_valid);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

bind endur_engine endur_engine_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .ERR_W  (ERR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .wr_count  (wr_count),
    .rd_count  (rd_count),
    .err_valid (err_valid),
    .err_total (err_total)
);

// File: tb/endur_engine_tb_top.sv
// Bench: memory model with random read corruption, directed and random
// address windows, run/stop segments; all checks from one process.
module endur_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int CW = 52;
    localparam int EW = 16;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic [AW-1:0] cfg_start = '0;
    logic [AW-1:0] cfg_end = '0;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy;
    logic [CW-1:0] wr_count;
    logic [CW-1:0] rd_count;
    logic          err_valid;
    logic [EW-1:0] err_total;
    logic [CW-1:0] err_wr_count;
    logic [CW-1:0] err_rd_count;
    logic [AW-1:0] err_addr;
    logic [DW-1:0] err_data;

    endur_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .ERR_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run),
        .cfg_start(cfg_start), .cfg_end(cfg_end),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .wr_count(wr_count), .rd_count(rd_count),
        .err_valid(err_valid), .err_total(err_total),
        .err_wr_count(err_wr_count), .err_rd_count(err_rd_count),
        .err_addr(err_addr), .err_data(err_data)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // Bench state
    int            n_chk = 0;
    int            n_fail = 0;
    int            cyc = 0;
    logic [DW-1:0] mem [1<<AW];
    logic [DW-1:0] pat_p;
    logic [63:0]   wr_n = 0;
    logic [63:0]   rd_n = 0;
    logic [63:0]   errs = 0;
    logic          armed = 1'b0;
    logic          first_acc = 1'b0;
    logic          inverted = 1'b0;
    int            phase = 0;
    logic [AW-1:0] lo = '0;
    logic [AW-1:0] hi = '0;
    logic [AW-1:0] exp_addr = '0;
    logic          rd_pend = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_pat = '0;
    logic          xe_pend = 1'b0;
    logic [63:0]   xe_total = 0;
    logic [63:0]   xe_wr = 0;
    logic [63:0]   xe_rd = 0;
    logic [AW-1:0] xe_addr = '0;
    logic [DW-1:0] xe_data = '0;

    function automatic logic [DW-1:0] make_pat();
        logic [DW-1:0] p;
        for (int i = 0; i < DW; i++) p[i] = ((i % 2) == 0);
        return p;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Memory model and bus checker, once per cycle at the falling edge
    task automatic model_step();
        logic [DW-1:0] got;
        logic [DW-1:0] mask;
        string         areq;
        if (!rst_n) return;
        // Error record against the miscompare predicted one cycle earlier
        if (err_valid) begin
            check(xe_pend, "R4", "error pulse without corrupted read", 1, 0);
            if (xe_pend) begin
                check(err_total == xe_total[EW-1:0], "R4", "err_total", 64'(err_total), xe_total);
                check(err_rd_count == xe_rd[CW-1:0], "R5", "err_rd_count", 64'(err_rd_count), xe_rd);
                check(err_wr_count == xe_wr[CW-1:0], "R5", "err_wr_count", 64'(err_wr_count), xe_wr);
                check(err_addr == xe_addr, "R5", "err_addr", 64'(err_addr), 64'(xe_addr));
                check(err_data == xe_data, "R5", "err_data", 64'(err_data), 64'(xe_data));
            end
            xe_pend = 1'b0;
        end else if (xe_pend) begin
            check(1'b0, "R4", "missing error pulse", 0, 1);
            xe_pend = 1'b0;
        end
        mem_rvalid = 1'b0;
        if (rd_pend) begin
            check(!mem_req, "R2", "request while read outstanding", 64'(mem_req), 0);
            mask = ($urandom_range(0, 7) == 0) ? DW'($urandom_range(1, (1 << DW) - 1)) : '0;
            got = mem[rd_addr] ^ mask;
            mem_rdata = got;
            mem_rvalid = 1'b1;
            rd_pend = 1'b0;
            if (got != rd_pat) begin
                errs++;
                xe_pend = 1'b1;
                xe_total = errs;
                xe_rd = rd_n;
                xe_wr = wr_n;
                xe_addr = rd_addr;
                xe_data = got;
            end
        end else if (mem_req) begin
            check(armed, "R8", "request while stopped", 64'(mem_addr), 0);
            areq = first_acc ? "R9" : (inverted ? "R7" : "R6");
            check(mem_addr == exp_addr, areq, "access address", 64'(mem_addr), 64'(exp_addr));
            check(mem_we == (phase == 0 || phase == 2), "R2", "access kind", 64'(mem_we), 64'(phase));
            if (phase == 0 || phase == 2)
                check(mem_wdata == ((phase == 0) ? pat_p : ~pat_p), "R2", "write pattern",
                      64'(mem_wdata), 64'((phase == 0) ? pat_p : ~pat_p));
            first_acc = 1'b0;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_n++;
            end else begin
                rd_n++;
                rd_pend = 1'b1;
                rd_addr = mem_addr;
                rd_pat = (phase == 1) ? pat_p : ~pat_p;
            end
            phase++;
            if (phase == 4) begin
                phase = 0;
                exp_addr = (exp_addr == hi) ? lo : exp_addr + AW'(1);
            end
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                check(1'b0, "R2", "watchdog expired", 64'(cyc), WATCHDOG);
                report();
            end
            model_step();
        end
    endtask

    // One run segment over window [s, e]
    task automatic run_seg(input logic [AW-1:0] s, input logic [AW-1:0] e, input int len);
        logic [CW-1:0] snap_rd;
        logic [CW-1:0] snap_wr;
        cfg_start = s;
        cfg_end = e;
        lo = s;
        hi = (s > e) ? s : e;
        inverted = (s > e);
        exp_addr = s;
        phase = 0;
        first_acc = 1'b1;
        armed = 1'b1;
        run = 1'b1;
        tick(len);
        run = 1'b0;
        for (int i = 0; i < 40 && busy; i++) tick(1);
        check(!busy, "R8", "busy after stop", 64'(busy), 0);
        check(phase == 0 && !rd_pend, "R8", "stopped mid-iteration", 64'(phase), 0);
        armed = 1'b0;
        snap_rd = rd_count;
        snap_wr = wr_count;
        tick(12);
        check(rd_count == snap_rd, "R8", "rd_count held", 64'(rd_count), 64'(snap_rd));
        check(wr_count == snap_wr, "R8", "wr_count held", 64'(wr_count), 64'(snap_wr));
        check(rd_count == rd_n[CW-1:0], "R3", "rd_count", 64'(rd_count), rd_n);
        check(wr_count == wr_n[CW-1:0], "R3", "wr_count", 64'(wr_count), wr_n);
        check(err_total == errs[EW-1:0], "R4", "err_total held", 64'(err_total), errs);
    endtask

    initial begin
        logic [AW-1:0] rs;
        logic [AW-1:0] re;
        void'($urandom(32'd20240611));
        pat_p = make_pat();
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        check(!mem_req, "R1", "mem_req", 64'(mem_req), 0);
        check(!busy, "R1", "busy", 64'(busy), 0);
        check(!err_valid, "R1", "err_valid", 64'(err_valid), 0);
        check(wr_count == '0, "R1", "wr_count", 64'(wr_count), 0);
        check(rd_count == '0, "R1", "rd_count", 64'(rd_count), 0);
        check(err_total == '0, "R1", "err_total", 64'(err_total), 0);
        // Directed windows: single word, small range, reversed bounds, top of space
        run_seg(6'd5, 6'd5, 150);
        run_seg(6'd10, 6'd13, 300);
        run_seg(6'd20, 6'd10, 150);
        run_seg(6'd60, 6'd63, 300);
        run_seg(6'd0, 6'd0, 40);
        // Random small windows, sometimes reversed
        for (int k = 0; k < 12; k++) begin
            rs = AW'($urandom_range(0, (1 << AW) - 1));
            if ($urandom_range(0, 3) == 0) re = AW'($urandom_range(0, (1 << AW) - 1));
            else re = (rs > AW'((1 << AW) - 4)) ? AW'((1 << AW) - 1) : rs + AW'($urandom_range(0, 3));
            run_seg(rs, re, $urandom_range(30, 400));
        end
        report();
    end

endmodule